// File: doc/BRIEF.md
# Branch Execution Unit

This block resolves one pre-decoded branch operation per cycle for a 64-bit core. Each operation carries a kind code, an absolute-address flag, a link flag, a five-bit branch-options field, a condition-bit selector, a hint field and a displacement. Alongside it the unit receives the current instruction address, the 32-bit condition word, and the counter, link and target special registers. From these it computes a taken flag and the next instruction address. It also computes an optional return address to be written to the link register, and an optional decremented counter to be written back.

The unit sits between the decoder and the register write-back path. A valid/ready handshake accepts an operation into a single output register stage. The control module decides whether the branch is taken and which write-backs happen, and sends its decisions to the datapath as a small strobe bundle. The datapath computes every candidate address, the decremented counter and the selected condition bit.

Operation kinds are: 0 = relative/absolute jump with a 24-bit displacement, 1 = conditional jump with a 14-bit displacement, 2 = conditional jump to the link register, 3 = conditional jump to the counter register, 4 = conditional jump to the target register. Codes 5 to 7 are not valid operations.

Top module: `brx_unit`

## Requirements
- R1: After reset, outValid, niaOk, lrWrOk and ctrWrOk are 0 and inReady is 1.
- R2: An operation is accepted on a clock edge where inValid and inReady are both 1. Its result shows on the outputs with outValid = 1 after that edge. inReady is 1 whenever outValid is 0 or outReady is 1. While outValid is 1 and outReady is 0, all outputs hold their values.
- R3: Kind 0 is always taken. Its target is base + sign-extended dispField[23:0] × 4, where base is 0 when absAddr = 1 and cia otherwise.
- R4: Kind 1 targets base + sign-extended dispField[13:0] × 4, with the same base rule as R3.
- R5: Condition test: boField[4] = 1 makes it pass. Otherwise it passes when crWord[31 − biSel] equals boField[3], so biSel = 0 selects the most significant bit.
- R6: For kinds 1, 2 and 4 with boField[2] = 0, the counter is decremented (ctrIn − 1) and the counter test applies to the decremented value. It passes when (decremented == 0) equals boField[1]. In this case ctrWrOk = 1 and ctrWrData is the decremented value. When boField[2] = 1, the counter test passes and ctrWrOk = 0.
- R7: Kind 3 never decrements the counter: its counter test always passes and ctrWrOk = 0.
- R8: Kinds 2, 3 and 4 take their target from lrIn, ctrIn and tarIn respectively, with the two low bits forced to 0. absAddr has no effect on them.
- R9: A conditional kind is taken when both the condition test and the counter test pass. niaOk equals the taken flag. nia is the target when taken and 0 otherwise. Kinds 5 to 7 are never taken and request no write-back.
- R10: For a valid kind, lrWrOk equals linkEn and lrWrData is cia + 4, whether or not the branch is taken.
- R11: bhHint has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present |
| inReady | output | 1 | Unit can accept an operation |
| opKind | input | 3 | Operation kind code |
| absAddr | input | 1 | Displacement is an absolute address |
| linkEn | input | 1 | Request return-address write |
| boField | input | 5 | Branch options |
| biSel | input | 5 | Condition bit selector |
| bhHint | input | 2 | Prediction hint, ignored |
| dispField | input | 24 | Word displacement (low 14 bits for kind 1) |
| cia | input | 64 | Current instruction address |
| crWord | input | 32 | Condition word |
| ctrIn | input | 64 | Counter register value |
| lrIn | input | 64 | Link register value |
| tarIn | input | 64 | Target register value |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| niaOk | output | 1 | Branch taken, nia valid |
| nia | output | 64 | Next instruction address |
| lrWrOk | output | 1 | Link register write requested |
| lrWrData | output | 64 | Return address |
| ctrWrOk | output | 1 | Counter write requested |
| ctrWrData | output | 64 | Decremented counter |

## Verification
The alignment property on taken results assumes that cia, and therefore every relative target, is word aligned. The stimulus uses only word-aligned instruction addresses, while the register operands it supplies carry nonzero low bits so that the masking is exercised. The hold property assumes that the consumer drops outReady only while a result is pending. The bench holds operands steady across each accepted cycle and changes them only at falling edges.

// File: rtl/brx_pkg.sv
package brx_pkg;

  typedef enum logic [2:0] {
    OP_JUMP      = 3'd0,
    OP_COND      = 3'd1,
    OP_VIA_LINK  = 3'd2,
    OP_VIA_COUNT = 3'd3,
    OP_VIA_TAR   = 3'd4
  } brKindT;

  typedef enum logic [2:0] {
    TGT_REL_LONG  = 3'd0,
    TGT_REL_SHORT = 3'd1,
    TGT_LINK      = 3'd2,
    TGT_COUNT     = 3'd3,
    TGT_TAR       = 3'd4
  } tgtSelT;

  typedef struct packed {
    logic   loadEn;
    logic   niaOk;
    logic   lrWr;
    logic   ctrWr;
    tgtSelT tgtSel;
  } brStrobeT;

  localparam int BO_W = 5;

endpackage

// File: rtl/brx_ctrl.sv
module brx_ctrl
  import brx_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic            outReady,
  output logic            outValid,
  input  logic [2:0]      opKind,
  input  logic            linkEn,
  input  logic [BO_W-1:0] boField,
  input  logic            crBit,
  input  logic            ctrDecZero,
  output brStrobeT        strobe
);

  brKindT kind;
  logic   fire;
  logic   condOk;
  logic   decReq;
  logic   ctrOk;
  logic   taken;
  logic   kindValid;
  tgtSelT tgtSel;
  logic   unusedBo;

  assign kind     = brKindT'(opKind);
  assign inReady  = !outValid || outReady;
  assign fire     = inValid && inReady;
  assign unusedBo = boField[0];

  // condition test: bit 4 bypasses, bit 3 is the wanted sense
  assign condOk = boField[4] || (crBit == boField[3]);

  // counter test uses the already-decremented value
  always_comb begin
    decReq = 1'b0;
    if (!boField[2]) begin
      case (kind)
        OP_COND, OP_VIA_LINK, OP_VIA_TAR: decReq = 1'b1;
        default:                          decReq = 1'b0;
      endcase
    end
  end

  assign ctrOk = !decReq || (ctrDecZero == boField[1]);

  always_comb begin
    taken     = 1'b0;
    tgtSel    = TGT_REL_LONG;
    kindValid = 1'b1;
    case (kind)
      OP_JUMP: begin
        taken  = 1'b1;
        tgtSel = TGT_REL_LONG;
      end
      OP_COND: begin
        taken  = condOk && ctrOk;
        tgtSel = TGT_REL_SHORT;
      end
      OP_VIA_LINK: begin
        taken  = condOk && ctrOk;
        tgtSel = TGT_LINK;
      end
      OP_VIA_COUNT: begin
        taken  = condOk;
        tgtSel = TGT_COUNT;
      end
      OP_VIA_TAR: begin
        taken  = condOk && ctrOk;
        tgtSel = TGT_TAR;
      end
      default: begin
        taken     = 1'b0;
        kindValid = 1'b0;
      end
    endcase
  end

  always_comb begin
    strobe.loadEn = fire;
    strobe.niaOk  = taken;
    strobe.lrWr   = linkEn && kindValid;
    strobe.ctrWr  = decReq;
    strobe.tgtSel = tgtSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         outValid <= 1'b0;
    else if (fire)     outValid <= 1'b1;
    else if (outReady) outValid <= 1'b0;
  end

  // R2: an idle stage always accepts
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  // R2: an accepted operation yields a result next cycle
  assert_fire_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

endmodule

// File: rtl/brx_datapath.sv
module brx_datapath
  import brx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CR_W   = 32,
  parameter int LI_W   = 24,
  parameter int BD_W   = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  brStrobeT                 strobe,
  input  logic                     absAddr,
  input  logic [$clog2(CR_W)-1:0]  biSel,
  input  logic [LI_W-1:0]          dispField,
  input  logic [ADDR_W-1:0]        cia,
  input  logic [CR_W-1:0]          crWord,
  input  logic [ADDR_W-1:0]        ctrIn,
  input  logic [ADDR_W-1:0]        lrIn,
  input  logic [ADDR_W-1:0]        tarIn,
  output logic                     crBit,
  output logic                     ctrDecZero,
  output logic                     niaOk,
  output logic [ADDR_W-1:0]        nia,
  output logic                     lrWrOk,
  output logic [ADDR_W-1:0]        lrWrData,
  output logic                     ctrWrOk,
  output logic [ADDR_W-1:0]        ctrWrData
);

  localparam int SEL_W = $clog2(CR_W);
  localparam logic [SEL_W-1:0] TOP_BIT = SEL_W'(CR_W - 1);
  localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offLong;
  logic [ADDR_W-1:0] offShort;
  logic [ADDR_W-1:0] ctrDec;
  logic [ADDR_W-1:0] target;

  // big-endian bit numbering: selector 0 is the top bit
  assign crBit = crWord[TOP_BIT - biSel];

  assign ctrDec     = ctrIn - 1'b1;
  assign ctrDecZero = (ctrDec == '0);

  assign base     = absAddr ? '0 : cia;
  assign offLong  = {{(ADDR_W-LI_W-2){dispField[LI_W-1]}}, dispField, 2'b00};
  assign offShort = {{(ADDR_W-BD_W-2){dispField[BD_W-1]}}, dispField[BD_W-1:0], 2'b00};

  always_comb begin
    case (strobe.tgtSel)
      TGT_REL_LONG:  target = base + offLong;
      TGT_REL_SHORT: target = base + offShort;
      TGT_LINK:      target = lrIn & WORD_MASK;
      TGT_COUNT:     target = ctrIn & WORD_MASK;
      TGT_TAR:       target = tarIn & WORD_MASK;
      default:       target = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      niaOk     <= 1'b0;
      nia       <= '0;
      lrWrOk    <= 1'b0;
      lrWrData  <= '0;
      ctrWrOk   <= 1'b0;
      ctrWrData <= '0;
    end else if (strobe.loadEn) begin
      niaOk     <= strobe.niaOk;
      nia       <= strobe.niaOk ? target : '0;
      lrWrOk    <= strobe.lrWr;
      lrWrData  <= cia + INSN_BYTES;
      ctrWrOk   <= strobe.ctrWr;
      ctrWrData <= ctrDec;
    end
  end

  // R9: a not-taken result carries no address
  assert_nia_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !niaOk |-> (nia == '0));

  // R8: register targets come out word aligned
  assert_reg_align_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && strobe.niaOk &&
     (strobe.tgtSel inside {TGT_LINK, TGT_COUNT, TGT_TAR}))
    |=> (nia[1:0] == 2'b00));

  // R10: return address is the following instruction
  assert_lr_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> (lrWrData == $past(cia) + INSN_BYTES));

  // R6: written counter is one less than the operand
  assert_ctr_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> (ctrWrData == $past(ctrIn) - 1'b1));

endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CR_W   = 32,
  parameter int LI_W   = 24,
  parameter int BD_W   = 14
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [2:0]               opKind,
  input  logic                     absAddr,
  input  logic                     linkEn,
  input  logic [BO_W-1:0]          boField,
  input  logic [$clog2(CR_W)-1:0]  biSel,
  input  logic [1:0]               bhHint,
  input  logic [LI_W-1:0]          dispField,
  input  logic [ADDR_W-1:0]        cia,
  input  logic [CR_W-1:0]          crWord,
  input  logic [ADDR_W-1:0]        ctrIn,
  input  logic [ADDR_W-1:0]        lrIn,
  input  logic [ADDR_W-1:0]        tarIn,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     niaOk,
  output logic [ADDR_W-1:0]        nia,
  output logic                     lrWrOk,
  output logic [ADDR_W-1:0]        lrWrData,
  output logic                     ctrWrOk,
  output logic [ADDR_W-1:0]        ctrWrData
);

  brStrobeT strobe;
  logic     crBit;
  logic     ctrDecZero;
  logic     unusedHint;

  // the hint only steers prediction elsewhere
  assign unusedHint = ^bhHint;

  brx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inReady    (inReady),
    .outReady   (outReady),
    .outValid   (outValid),
    .opKind     (opKind),
    .linkEn     (linkEn),
    .boField    (boField),
    .crBit      (crBit),
    .ctrDecZero (ctrDecZero),
    .strobe     (strobe)
  );

  brx_datapath #(
    .ADDR_W (ADDR_W),
    .CR_W   (CR_W),
    .LI_W   (LI_W),
    .BD_W   (BD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .absAddr    (absAddr),
    .biSel      (biSel),
    .dispField  (dispField),
    .cia        (cia),
    .crWord     (crWord),
    .ctrIn      (ctrIn),
    .lrIn       (lrIn),
    .tarIn      (tarIn),
    .crBit      (crBit),
    .ctrDecZero (ctrDecZero),
    .niaOk      (niaOk),
    .nia        (nia),
    .lrWrOk     (lrWrOk),
    .lrWrData   (lrWrData),
    .ctrWrOk    (ctrWrOk),
    .ctrWrData  (ctrWrData)
  );

  // R2: a stalled result does not change
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (outValid && $stable(nia) && $stable(niaOk) && $stable(lrWrOk) &&
       $stable(ctrWrOk) && $stable(ctrWrData)));

endmodule

// File: tb/sim_brx_unit.sv
`timescale 1ns/1ps
module sim_brx_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [2:0]  opKind = '0;
  logic        absAddr = 1'b0;
  logic        linkEn = 1'b0;
  logic [4:0]  boField = '0;
  logic [4:0]  biSel = '0;
  logic [1:0]  bhHint = '0;
  logic [23:0] dispField = '0;
  logic [63:0] cia = 64'h0000_0000_0001_0000;
  logic [31:0] crWord = 32'h8000_0001;
  logic [63:0] ctrIn = 64'd5;
  logic [63:0] lrIn = 64'h0000_0000_0002_0007;
  logic [63:0] tarIn = 64'h0000_0000_0003_000B;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        niaOk;
  logic [63:0] nia;
  logic        lrWrOk;
  logic [63:0] lrWrData;
  logic        ctrWrOk;
  logic [63:0] ctrWrData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brx_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opKind(opKind), .absAddr(absAddr), .linkEn(linkEn), .boField(boField),
    .biSel(biSel), .bhHint(bhHint), .dispField(dispField), .cia(cia),
    .crWord(crWord), .ctrIn(ctrIn), .lrIn(lrIn), .tarIn(tarIn),
    .outValid(outValid), .outReady(outReady), .niaOk(niaOk), .nia(nia),
    .lrWrOk(lrWrOk), .lrWrData(lrWrData), .ctrWrOk(ctrWrOk),
    .ctrWrData(ctrWrData)
  );

  // {kind[39:37], abs[36], link[35], bo[34:30], bi[29:25], disp[24:1], taken[0]}
  localparam int NVEC = 12;
  localparam logic [39:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 5'd0,  5'd0,  24'h000010, 1'b1}, // R3 relative
    {3'd0, 1'b1, 1'b1, 5'd0,  5'd0,  24'hFFFFFF, 1'b1}, // R3 absolute + link
    {3'd1, 1'b0, 1'b0, 5'd20, 5'd0,  24'h003FFE, 1'b1}, // R4 backward
    {3'd1, 1'b0, 1'b0, 5'd12, 5'd0,  24'h000020, 1'b1}, // R5 true, bit set
    {3'd1, 1'b0, 1'b0, 5'd12, 5'd1,  24'h000020, 1'b0}, // R5 true, bit clear
    {3'd1, 1'b0, 1'b0, 5'd4,  5'd1,  24'h000020, 1'b1}, // R5 false, bit clear
    {3'd1, 1'b0, 1'b1, 5'd16, 5'd0,  24'h000020, 1'b1}, // R6 nonzero test
    {3'd1, 1'b0, 1'b0, 5'd18, 5'd0,  24'h000020, 1'b0}, // R6 zero test fails
    {3'd2, 1'b0, 1'b1, 5'd20, 5'd0,  24'h000000, 1'b1}, // R8 link target
    {3'd3, 1'b0, 1'b0, 5'd20, 5'd0,  24'h000000, 1'b1}, // R8 counter target
    {3'd4, 1'b1, 1'b0, 5'd12, 5'd31, 24'h000000, 1'b1}, // R8 tar, abs ignored
    {3'd2, 1'b0, 1'b0, 5'd4,  5'd0,  24'h000000, 1'b0}  // R9 not taken
  };

  function automatic logic [63:0] modelTarget(input logic [2:0] k, input logic a,
                                              input logic [23:0] d);
    logic [63:0] b;
    b = a ? 64'd0 : cia;
    case (k)
      3'd0: return b + {{38{d[23]}}, d, 2'b00};
      3'd1: return b + {{48{d[13]}}, d[13:0], 2'b00};
      3'd2: return lrIn & ~64'd3;
      3'd3: return ctrIn & ~64'd3;
      3'd4: return tarIn & ~64'd3;
      default: return 64'd0;
    endcase
  endfunction

  task automatic drive(input logic [2:0] k, input logic a, input logic l,
                       input logic [4:0] bo, input logic [4:0] bi,
                       input logic [1:0] bh, input logic [23:0] d);
    @(negedge clk);
    opKind = k; absAddr = a; linkEn = l; boField = bo; biSel = bi;
    bhHint = bh; dispField = d; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOp(input string tag, input logic [2:0] k, input logic a,
                         input logic l, input logic [4:0] bo,
                         input logic [23:0] d, input logic expTaken);
    logic expCtr;
    expCtr = (k == 3'd1 || k == 3'd2 || k == 3'd4) && !bo[2];
    check({tag, " taken/valid"}, {62'd0, outValid, niaOk}, {62'd0, 1'b1, expTaken});
    check({tag, " nia"}, nia, expTaken ? modelTarget(k, a, d) : 64'd0);
    check({tag, " link"}, {63'd0, lrWrOk}, {63'd0, l});
    if (l) check({tag, " link data"}, lrWrData, cia + 64'd4);
    check({tag, " ctr write"}, {63'd0, ctrWrOk}, {63'd0, expCtr});
    if (expCtr) check({tag, " ctr data"}, ctrWrData, ctrIn - 64'd1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {60'd0, outValid, niaOk, lrWrOk, ctrWrOk}, 64'd0);
    check("R1 reset ready", {63'd0, inReady}, 64'd1);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      v = VEC[i];
      drive(v[39:37], v[36], v[35], v[34:30], v[29:25], 2'b00, v[24:1]);
      checkOp($sformatf("R3-R10 vec%0d", i), v[39:37], v[36], v[35],
              v[34:30], v[24:1], v[0]);
    end

    // R6 counter of 1 reaches zero after decrement
    ctrIn = 64'd1;
    drive(3'd1, 1'b0, 1'b0, 5'd18, 5'd0, 2'b00, 24'h000040);
    checkOp("R6 ctr1 zero-test", 3'd1, 1'b0, 1'b0, 5'd18, 24'h000040, 1'b1);
    check("R6 ctr1 written zero", ctrWrData, 64'd0);
    drive(3'd1, 1'b0, 1'b0, 5'd16, 5'd0, 2'b00, 24'h000040);
    checkOp("R6 ctr1 nonzero-test", 3'd1, 1'b0, 1'b0, 5'd16, 24'h000040, 1'b0);

    // R6 counter of 0 wraps to all ones
    ctrIn = 64'd0;
    drive(3'd4, 1'b0, 1'b0, 5'd16, 5'd0, 2'b00, 24'h0);
    checkOp("R6 ctr0 wrap", 3'd4, 1'b0, 1'b0, 5'd16, 24'h0, 1'b1);
    check("R6 ctr0 data", ctrWrData, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7 counter-target kind ignores decrement request
    ctrIn = 64'd1;
    drive(3'd3, 1'b0, 1'b0, 5'd18, 5'd0, 2'b00, 24'h0);
    check("R7 taken", {63'd0, niaOk}, 64'd1);
    check("R7 no ctr write", {63'd0, ctrWrOk}, 64'd0);
    check("R7 nia", nia, 64'd0);
    ctrIn = 64'd5;

    // R11 hint varied, results unchanged
    drive(3'd1, 1'b0, 1'b1, 5'd12, 5'd0, 2'b11, 24'h000100);
    checkOp("R11 hint=3", 3'd1, 1'b0, 1'b1, 5'd12, 24'h000100, 1'b1);
    drive(3'd1, 1'b0, 1'b0, 5'd12, 5'd1, 2'b10, 24'h000100);
    checkOp("R11 hint=2 not taken", 3'd1, 1'b0, 1'b0, 5'd12, 24'h000100, 1'b0);

    // R9 invalid kind
    drive(3'd6, 1'b0, 1'b1, 5'd20, 5'd0, 2'b00, 24'h000010);
    check("R9 invalid kind", {61'd0, niaOk, lrWrOk, ctrWrOk}, 64'd0);

    // R2 backpressure
    @(negedge clk);
    outReady = 1'b0;
    drive(3'd0, 1'b0, 1'b0, 5'd0, 5'd0, 2'b00, 24'h000008);
    check("R2 stalled ready", {62'd0, outValid, inReady}, {62'd0, 1'b1, 1'b0});
    check("R2 first result", nia, cia + 64'd32);
    drive(3'd0, 1'b0, 1'b0, 5'd0, 5'd0, 2'b00, 24'h000100);
    check("R2 held result", nia, cia + 64'd32);
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 drained", {63'd0, outValid}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule